// File: doc/BRIEF.md
# Channel Address and Count Register Bank

This block keeps, for a set of transfer channels, the sixteen-bit programmed start address, the sixteen-bit programmed count, the latched starting address and a running tally of bytes moved. Software reaches all of it through one byte-wide access path. Every channel owns two access slots: an address slot and a count slot. Each sixteen-bit value is moved as two bytes. A single shared byte pointer, kept as a two-state machine, picks which byte an access touches.

The pointer has two states, `PTR_LO` and `PTR_HI`. Three transitions move it:
- FLIP: any accepted read or write moves it to the other state.
- CLEAR: the `ptr_clear` input forces it to `PTR_LO`.
- HOLD: with neither of the above, it stays where it is.

Writing the upper byte of either slot restarts the channel. The starting address is latched from the programmed address, and the tally returns to zero.

A transfer engine reports progress one element at a time on `step_en` and `step_chan`. The block hands back a live byte address and a transfer length for every channel. When `SHIFT` is 1, the instance serves a word-wide controller. The programmed values are then counted in words and doubled into byte terms. Readbacks are halved back to word terms, and each step advances two bytes.

Top module: `dma_chan_regs`

## Requirements
- R1: The access port value splits in two. Bit 0 selects the address slot (0) or the count slot (1). The bits above it give the channel number, so with 4 channels port value 2*c+s reaches channel c, slot s. An access reaches no other channel.
- R2: The pointer is `PTR_LO` (`ptr_hi`=0) after reset. Each cycle with `acc_wr` or `acc_rd` high moves it to the other state. When it is `PTR_LO` an access touches bits [7:0], and when it is `PTR_HI` an access touches bits [15:8].
- R3: When `ptr_clear` is high, the pointer is `PTR_LO` after that edge, even if an access happens in the same cycle.
- R4: A lower-byte write changes only the programmed value. It does not change the live address `cur_addr` or the tally.
- R5: An upper-byte write to either slot does three things: it loads the upper byte, latches the starting address as the programmed address shifted left by `SHIFT`, and zeroes the tally. A step in that same cycle is lost.
- R6: A read returns the selected byte in `acc_rdata` one cycle later. For the address slot, the value is (starting address plus tally) shifted right by `SHIFT` when `dir_down` for that channel is 0. When `dir_down` is 1, it is (starting address minus tally) shifted right by `SHIFT`. `acc_rdata` changes only after a read.
- R7: A read of the count slot returns ((programmed count shifted left by `SHIFT`) minus tally) shifted right by `SHIFT`.
- R8: A cycle with `step_en` high adds 2^`SHIFT` bytes to the tally of channel `step_chan` and of no other channel. The live byte address `cur_addr` is the starting address plus the tally, or minus it when `dir_down` is 1.
- R9: With `SHIFT`=1, a programmed address A gives `cur_addr` = 2A. One step then adds 2 to `cur_addr` and 1 to the address readback, and removes 1 from the count readback.
- R10: `xfer_len` of each channel equals (programmed count + 1) shifted left by `SHIFT`.
- R11: After reset, every programmed value, starting address and tally is zero, and `acc_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_wr | input | 1 | Byte write strobe |
| acc_rd | input | 1 | Byte read strobe |
| acc_port | input | $clog2(NCH)+1 | Channel and slot select |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid the cycle after `acc_rd` |
| ptr_clear | input | 1 | Force byte pointer to low |
| ptr_hi | output | 1 | Byte pointer state |
| dir_down | input | NCH | Per-channel descending-address flag |
| step_en | input | 1 | One element moved |
| step_chan | input | $clog2(NCH) | Channel that moved it |
| cur_addr | output | NCH x (16+SHIFT) | Live byte address per channel |
| xfer_len | output | NCH x (17+SHIFT) | Transfer length in bytes per channel |

## Verification
The assertions assume that the system never raises `acc_wr` and `acc_rd` in the same cycle. They also assume that `step_chan` names an existing channel whenever `step_en` is high. The tasks drive each strobe for a single cycle, always one at a time, and only step channels 0 to 3. The tally is free to wrap. The stimulus keeps step counts far below the programmed counts, so no check depends on wraparound.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
    localparam int BYTEW = 8;
    localparam int REGW  = 2 * BYTEW;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_e;
endpackage

// File: rtl/dmaregs_ptr_fsm.sv
module dmaregs_ptr_fsm
    import dmaregs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic clr,
    output ptr_e state,
    output logic hi
);
    ptr_e state_nx;

    // next state: CLEAR beats FLIP, otherwise HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            PTR_LO: if (clr) state_nx = PTR_LO;
                    else if (acc) state_nx = PTR_HI;
            PTR_HI: if (clr) state_nx = PTR_LO;
                    else if (acc) state_nx = PTR_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PTR_LO;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            PTR_LO: hi = 1'b0;
            PTR_HI: hi = 1'b1;
        endcase
    end

    a_r2_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !clr) |=> (state != $past(state)));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(state));
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == PTR_LO));
endmodule

// File: rtl/dmaregs_chan.sv
module dmaregs_chan
    import dmaregs_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  reg_sel,
    input  logic [BYTEW-1:0]      wdata,
    input  logic                  step,
    input  logic                  dir_down,
    output logic [REGW+SHIFT-1:0] cur_addr,
    output logic [REGW-1:0]       addr_rb,
    output logic [REGW-1:0]       cnt_rb,
    output logic [REGW+SHIFT:0]   xfer_len
);
    localparam int SW = REGW + SHIFT;
    localparam int LW = REGW + SHIFT + 1;
    localparam logic [SW-1:0] STEP = SW'(1) << SHIFT;

    logic [REGW-1:0] base_addr, base_cnt, new_addr;
    logic [SW-1:0]   start, done, cnt_scaled;

    // address that the upper-byte write latches
    assign new_addr = reg_sel ? base_addr : {wdata, base_addr[BYTEW-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            start     <= '0;
            done      <= '0;
        end else begin
            if (wr_lo) begin
                if (reg_sel) base_cnt[BYTEW-1:0]  <= wdata;
                else         base_addr[BYTEW-1:0] <= wdata;
            end
            if (wr_hi) begin
                if (reg_sel) base_cnt[REGW-1:BYTEW]  <= wdata;
                else         base_addr[REGW-1:BYTEW] <= wdata;
                start <= SW'(new_addr) << SHIFT;
                done  <= '0;
            end else if (step) begin
                done <= done + STEP;
            end
        end
    end

    assign cur_addr   = dir_down ? (start - done) : (start + done);
    assign addr_rb    = REGW'(cur_addr >> SHIFT);
    assign cnt_scaled = (SW'(base_cnt) << SHIFT) - done;
    assign cnt_rb     = REGW'(cnt_scaled >> SHIFT);
    assign xfer_len   = (LW'(base_cnt) + LW'(1)) << SHIFT;

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (done == '0));
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_hi) |=> (done == $past(done) + STEP));
    a_r4_lo_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !step) |=> ($stable(start) && $stable(done)));
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !step) |=> $stable(done));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmaregs_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SHIFT = 0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 acc_wr,
    input  logic                                 acc_rd,
    input  logic [$clog2(NCH):0]                 acc_port,
    input  logic [7:0]                           acc_wdata,
    output logic [7:0]                           acc_rdata,
    input  logic                                 ptr_clear,
    output logic                                 ptr_hi,
    input  logic [NCH-1:0]                       dir_down,
    input  logic                                 step_en,
    input  logic [$clog2(NCH)-1:0]               step_chan,
    output logic [NCH-1:0][REGW+SHIFT-1:0]       cur_addr,
    output logic [NCH-1:0][REGW+SHIFT:0]         xfer_len
);
    localparam int CHW = $clog2(NCH);

    ptr_e           ptr;
    logic           acc, rsel;
    logic [CHW-1:0] ch;
    logic [NCH-1:0] wr_lo_v, wr_hi_v;
    logic [NCH-1:0][REGW-1:0] addr_rb, cnt_rb;
    logic [REGW-1:0] word_sel;

    assign acc  = acc_wr | acc_rd;
    assign rsel = acc_port[0];
    assign ch   = acc_port[CHW:1];

    dmaregs_ptr_fsm u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .clr   (ptr_clear),
        .state (ptr),
        .hi    (ptr_hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign wr_lo_v[g] = acc_wr && (ch == CHW'(g)) && (ptr == PTR_LO);
        assign wr_hi_v[g] = acc_wr && (ch == CHW'(g)) && (ptr == PTR_HI);

        dmaregs_chan #(.SHIFT(SHIFT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo_v[g]),
            .wr_hi    (wr_hi_v[g]),
            .reg_sel  (rsel),
            .wdata    (acc_wdata),
            .step     (step_en && (step_chan == CHW'(g))),
            .dir_down (dir_down[g]),
            .cur_addr (cur_addr[g]),
            .addr_rb  (addr_rb[g]),
            .cnt_rb   (cnt_rb[g]),
            .xfer_len (xfer_len[g])
        );
    end

    assign word_sel = rsel ? cnt_rb[ch] : addr_rb[ch];

    // a write wins over a read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_rdata <= '0;
        else if (acc_rd && !acc_wr)
            acc_rdata <= (ptr == PTR_HI) ? word_sel[REGW-1:BYTEW] : word_sel[BYTEW-1:0];
    end

    a_r1_one_chan: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo_v, wr_hi_v}));
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd && !acc_wr) |=> $stable(acc_rdata));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic acc_wr = 0, acc_rd = 0, ptr_clear = 0, step_en = 0;
    logic [2:0] acc_port = '0;
    logic [7:0] acc_wdata = '0, rd_b, rd_w;
    logic [3:0] dir_down = '0;
    logic [1:0] step_chan = '0;
    logic hi_b, hi_w;
    logic [3:0][15:0] ca_b;
    logic [3:0][16:0] ca_w, len_b;
    logic [3:0][17:0] len_w;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs #(.NCH(4), .SHIFT(0)) i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(rd_b),
        .ptr_clear(ptr_clear), .ptr_hi(hi_b), .dir_down(dir_down),
        .step_en(step_en), .step_chan(step_chan), .cur_addr(ca_b), .xfer_len(len_b));

    dma_chan_regs #(.NCH(4), .SHIFT(1)) i_dma_chan_regs_w (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .acc_rdata(rd_w),
        .ptr_clear(ptr_clear), .ptr_hi(hi_w), .dir_down(dir_down),
        .step_en(step_en), .step_chan(step_chan), .cur_addr(ca_w), .xfer_len(len_w));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] p, input logic [7:0] d);
        @(negedge clk); acc_wr = 1; acc_port = p; acc_wdata = d;
        @(negedge clk); acc_wr = 0;
    endtask

    task automatic rd(input logic [2:0] p);
        @(negedge clk); acc_rd = 1; acc_port = p;
        @(negedge clk); acc_rd = 0;
    endtask

    task automatic steps(input logic [1:0] c, input int n);
        @(negedge clk); step_en = 1; step_chan = c;
        repeat (n) @(negedge clk);
        step_en = 0;
    endtask

    task automatic clear_ptr();
        @(negedge clk); ptr_clear = 1;
        @(negedge clk); ptr_clear = 0;
    endtask

    task automatic t_reset();
        chk("R11 ptr", hi_b, 0);
        chk("R11 cur_addr ch2", ca_b[2], 0);
        chk("R11 rdata", rd_b, 0);
        chk("R10 len at reset", len_b[0], 1);
    endtask

    task automatic t_write_addr();
        wr(3'd4, 8'h34);
        chk("R4 low write no reload", ca_b[2], 0);
        chk("R2 ptr after one access", hi_b, 1);
        wr(3'd4, 8'h12);
        chk("R5 reload cur_addr", ca_b[2], 16'h1234);
        chk("R2 ptr back low", hi_b, 0);
        chk("R1 other channel ch1", ca_b[1], 0);
        chk("R1 other channel ch3", ca_b[3], 0);
    endtask

    task automatic t_read_addr();
        rd(3'd4); chk("R6 addr lo", rd_b, 8'h34);
        rd(3'd4); chk("R6 addr hi", rd_b, 8'h12);
    endtask

    task automatic t_count_steps();
        wr(3'd5, 8'h0F); wr(3'd5, 8'h00);
        chk("R10 len ch2", len_b[2], 17'h10);
        steps(2'd2, 3);
        chk("R8 cur_addr up", ca_b[2], 16'h1237);
        chk("R8 ch1 untouched", ca_b[1], 0);
        rd(3'd5); chk("R7 count lo", rd_b, 8'h0C);
        rd(3'd5); chk("R7 count hi", rd_b, 8'h00);
        rd(3'd4); chk("R6 addr up lo", rd_b, 8'h37);
        rd(3'd4); chk("R6 addr up hi", rd_b, 8'h12);
    endtask

    task automatic t_down();
        @(negedge clk); dir_down = 4'b0100;
        @(negedge clk);
        chk("R8 cur_addr down", ca_b[2], 16'h1231);
        rd(3'd4); chk("R6 addr down lo", rd_b, 8'h31);
        rd(3'd4); chk("R6 addr down hi", rd_b, 8'h12);
    endtask

    task automatic t_low_no_reload();
        wr(3'd4, 8'h99);
        chk("R4 cur_addr kept", ca_b[2], 16'h1231);
        wr(3'd4, 8'h12);
        chk("R5 reload after hi", ca_b[2], 16'h1299);
        rd(3'd5); chk("R5 tally zeroed count lo", rd_b, 8'h0F);
        rd(3'd5); chk("R7 count hi", rd_b, 8'h00);
    endtask

    task automatic t_clear();
        wr(3'd0, 8'h55);
        chk("R2 ptr high", hi_b, 1);
        clear_ptr();
        chk("R3 clear alone", hi_b, 0);
        @(negedge clk); acc_rd = 1; acc_port = 3'd0; ptr_clear = 1;
        @(negedge clk); acc_rd = 0; ptr_clear = 0;
        chk("R3 clear beats toggle", hi_b, 0);
    endtask

    task automatic t_reload_vs_step();
        wr(3'd6, 8'h00);
        @(negedge clk); acc_wr = 1; acc_port = 3'd6; acc_wdata = 8'hAB;
        step_en = 1; step_chan = 2'd3;
        @(negedge clk); acc_wr = 0; step_en = 0;
        chk("R5 step lost on reload", ca_b[3], 16'hAB00);
    endtask

    task automatic t_word();
        wr(3'd0, 8'h34); wr(3'd0, 8'h12);
        chk("R9 word cur_addr", ca_w[0], 17'h2468);
        wr(3'd1, 8'h03); wr(3'd1, 8'h00);
        chk("R10 word len", len_w[0], 18'd8);
        steps(2'd0, 1);
        chk("R9 word step", ca_w[0], 17'h246A);
        rd(3'd0); chk("R9 word addr rb", rd_w, 8'h35);
        clear_ptr();
        rd(3'd1); chk("R9 word count rb", rd_w, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_addr();
        t_read_addr();
        t_count_steps();
        t_down();
        t_low_no_reload();
        t_clear();
        t_reload_vs_step();
        t_word();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule